// File: doc/BRIEF.md
# Flash-to-Memory DMA Transfer Engine

This block moves a run of bytes between a serial flash shift engine and system memory without processor help. Software first sets a 32-bit memory start address and a length word. The length word carries a byte count and a lane-width code. Software then writes a direction trigger. The engine works through the run one byte at a time. Each byte makes one trip through the shift engine's request/done port and one trip through a single-beat memory request/response port. At the end of the run the engine sets a pending flag, and that flag drives an interrupt line through an enable bit.

The register slice sits inside the block. It holds the configuration word, the trigger, the start address, the interrupt status and the length. Chip-select state and the flash pins belong to the shift engine and are never touched here. The start address and length registers are copied when a run begins. Software may therefore reprogram them while a run is in flight without disturbing it.

Top module: `flash_dma_engine`

## Requirements
- R1: After reset every readable register reads 0, `dma_busy` and `dma_irq` are low, and neither `mem_req_valid` nor `shift_req_valid` is asserted.
- R2: Writing 0 to the trigger register (offset 0x18) starts a flash-to-memory run. For byte k the engine asks the shift engine for a receive (`shift_req_tx`=0), using the lane code held in length bits 29:28 (0 single, 1 dual, 2 quad). It then issues a memory write (`mem_req_write`=1) of the received byte to start address + k. Addresses ascend by one and wrap modulo 2^32.
- R3: Writing 1 to the trigger register starts a memory-to-flash run. For byte k the engine issues a memory read of start address + k. It then sends the returned byte to the shift engine with `shift_req_tx`=1 and the programmed lane code.
- R4: The byte count is length bits 11:0. A flash-to-memory run moves at most 2080 bytes and a memory-to-flash run at most 520 bytes. A larger count is cut down to that limit.
- R5: A run with a byte count of 0 issues no memory or shift request, keeps `dma_busy` low and sets the pending flag within two cycles of the trigger write.
- R6: A trigger write made while a run is still in progress is ignored. It changes neither the direction nor the number of bytes moved.
- R7: `dma_busy` is high from the cycle after a trigger write with a nonzero count until the last byte has been handed off. It is low for at least one cycle before the pending flag rises.
- R8: Bit 0 of the interrupt status register (offset 0x20) is the pending flag. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R9: `dma_irq` is high exactly when the pending flag is set and config (offset 0x00) bit 20 is 1.
- R10: The registers read back as follows. Offset 0x00 returns only bit 20. Offset 0x1C returns the full start address. Offset 0x24 returns bits 29:28 and 11:0. The trigger register and all unmapped offsets read 0.
- R11: While a memory or shift request is asserted and not accepted, its valid stays high and its address, data, direction and lane fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write byte, 0 = read byte |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data |
| shift_req_valid | output | 1 | Shift engine byte request valid |
| shift_req_ready | input | 1 | Shift engine accepted the request |
| shift_req_tx | output | 1 | 1 = send a byte, 0 = receive a byte |
| shift_req_lanes | output | 2 | Lane-width code |
| shift_req_byte | output | 8 | Byte to send |
| shift_done_valid | input | 1 | Shift engine finished the byte |
| shift_done_byte | input | 8 | Received byte |
| dma_busy | output | 1 | Run in progress |
| dma_irq | output | 1 | Completion interrupt |

## Verification
A wrong pointer or a wrong remaining count shows up at the very next memory handshake. In that case the address does not follow the previous address plus one, or a request arrives after the scoreboard has run dry, or the run ends with expected bytes still queued. A corrupted byte register shows up as a wrong data byte on the handshake that follows its capture, in either direction. A fault in the sequencing or in the completion path shows up within one or two cycles. The symptoms are the interrupt rising while `dma_busy` is still high, `dma_busy` staying low after a nonzero trigger, or a second trigger changing what the run moves.

// File: rtl/flash_dma_pkg.sv
package flash_dma_pkg;

    // Register byte offsets decoded by the slice
    localparam logic [7:0] OFS_CONFIG = 8'h00;
    localparam logic [7:0] OFS_KICK   = 8'h18;
    localparam logic [7:0] OFS_BASE   = 8'h1C;
    localparam logic [7:0] OFS_EVENT  = 8'h20;
    localparam logic [7:0] OFS_SIZE   = 8'h24;

    // Bit positions inside the config and length words
    localparam int IRQ_EN_BIT = 20;
    localparam int LANE_HI    = 29;
    localparam int LANE_LO    = 28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SH_REQ,
        ST_SH_WAIT,
        ST_MEM_REQ,
        ST_MEM_WAIT,
        ST_FINISH
    } dma_state_e;

    typedef enum logic {
        DIR_TO_MEM   = 1'b0,
        DIR_TO_FLASH = 1'b1
    } dma_dir_e;

endpackage

// File: rtl/flash_dma_regs.sv
module flash_dma_regs
    import flash_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              run_active,
    input  logic              run_done,
    output logic              start,
    output dma_dir_e          start_dir,
    output logic [ADDR_W-1:0] base_addr,
    output logic [LEN_W-1:0]  byte_len,
    output logic [1:0]        lane_code,
    output logic              irq
);

    typedef struct packed {
        logic              irq_en;
        logic              pend;
        logic [ADDR_W-1:0] base;
        logic [1:0]        lanes;
        logic [LEN_W-1:0]  len;
    } regs_t;

    regs_t regs_d, regs_q;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata;

    always_comb begin
        regs_d    = regs_q;
        start     = 1'b0;
        start_dir = DIR_TO_MEM;
        if (wr_en) begin
            case (addr)
                OFS_CONFIG: regs_d.irq_en = wdata[IRQ_EN_BIT];
                OFS_BASE:   regs_d.base   = wdata[ADDR_W-1:0];
                OFS_SIZE: begin
                    regs_d.lanes = wdata[LANE_HI:LANE_LO];
                    regs_d.len   = wdata[LEN_W-1:0];
                end
                OFS_EVENT: begin
                    if (wdata[0]) regs_d.pend = 1'b0;
                end
                OFS_KICK: begin
                    if (!run_active) begin
                        start     = 1'b1;
                        start_dir = dma_dir_e'(wdata[0]);
                    end
                end
                default: ;
            endcase
        end
        // completion beats a same-cycle clear
        if (run_done) regs_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CONFIG: rdata[IRQ_EN_BIT] = regs_q.irq_en;
            OFS_BASE:   rdata[ADDR_W-1:0] = regs_q.base;
            OFS_EVENT:  rdata[0] = regs_q.pend;
            OFS_SIZE: begin
                rdata[LANE_HI:LANE_LO] = regs_q.lanes;
                rdata[LEN_W-1:0]       = regs_q.len;
            end
            default: rdata = '0;
        endcase
    end

    assign base_addr = regs_q.base;
    assign byte_len  = regs_q.len;
    assign lane_code = regs_q.lanes;
    assign irq       = regs_q.pend & regs_q.irq_en;

endmodule

// File: rtl/flash_dma_ctrl.sv
module flash_dma_ctrl
    import flash_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter int MAX_RD = 2080,
    parameter int MAX_WR = 520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  dma_dir_e          start_dir,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic [1:0]        lane_code,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [7:0]        mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    output logic              shift_req_valid,
    input  logic              shift_req_ready,
    output logic              shift_req_tx,
    output logic [1:0]        shift_req_lanes,
    output logic [7:0]        shift_req_byte,
    input  logic              shift_done_valid,
    input  logic [7:0]        shift_done_byte,
    output logic              busy,
    output logic              active,
    output logic              run_done
);

    localparam int MAX_ANY = (MAX_RD > MAX_WR) ? MAX_RD : MAX_WR;
    localparam int CNT_W   = $clog2(MAX_ANY + 1);
    localparam logic [LEN_W-1:0] LIM_RD = LEN_W'(MAX_RD);
    localparam logic [LEN_W-1:0] LIM_WR = LEN_W'(MAX_WR);

    typedef struct packed {
        dma_state_e        state;
        dma_dir_e          dir;
        logic [1:0]        lanes;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] ptr;
        logic [7:0]        data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LEN_W-1:0] limit;
    logic [CNT_W-1:0] clamped;

    always_comb begin
        limit   = (start_dir == DIR_TO_FLASH) ? LIM_WR : LIM_RD;
        clamped = (byte_len > limit) ? CNT_W'(limit) : CNT_W'(byte_len);
    end

    always_comb begin
        ctl_d    = ctl_q;
        run_done = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.dir   = start_dir;
                    ctl_d.lanes = lane_code;
                    ctl_d.ptr   = base_addr;
                    ctl_d.left  = clamped;
                    ctl_d.data  = '0;
                    if (clamped == '0)
                        ctl_d.state = ST_FINISH;
                    else if (start_dir == DIR_TO_FLASH)
                        ctl_d.state = ST_MEM_REQ;
                    else
                        ctl_d.state = ST_SH_REQ;
                end
            end
            ST_SH_REQ: begin
                if (shift_req_ready) ctl_d.state = ST_SH_WAIT;
            end
            ST_SH_WAIT: begin
                if (shift_done_valid) begin
                    if (ctl_q.dir == DIR_TO_MEM) begin
                        ctl_d.data  = shift_done_byte;
                        ctl_d.state = ST_MEM_REQ;
                    end else begin
                        ctl_d.left  = ctl_q.left - 1'b1;
                        ctl_d.ptr   = ctl_q.ptr + 1'b1;
                        ctl_d.state = (ctl_q.left == CNT_W'(1)) ? ST_FINISH : ST_MEM_REQ;
                    end
                end
            end
            ST_MEM_REQ: begin
                if (mem_req_ready) begin
                    if (ctl_q.dir == DIR_TO_MEM) begin
                        ctl_d.left  = ctl_q.left - 1'b1;
                        ctl_d.ptr   = ctl_q.ptr + 1'b1;
                        ctl_d.state = (ctl_q.left == CNT_W'(1)) ? ST_FINISH : ST_SH_REQ;
                    end else begin
                        ctl_d.state = ST_MEM_WAIT;
                    end
                end
            end
            ST_MEM_WAIT: begin
                if (mem_rsp_valid) begin
                    ctl_d.data  = mem_rsp_data;
                    ctl_d.state = ST_SH_REQ;
                end
            end
            ST_FINISH: begin
                run_done    = 1'b1;
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, dir: DIR_TO_MEM, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign mem_req_valid   = (ctl_q.state == ST_MEM_REQ);
    assign mem_req_write   = (ctl_q.dir == DIR_TO_MEM);
    assign mem_req_addr    = ctl_q.ptr;
    assign mem_req_wdata   = ctl_q.data;
    assign shift_req_valid = (ctl_q.state == ST_SH_REQ);
    assign shift_req_tx    = (ctl_q.dir == DIR_TO_FLASH);
    assign shift_req_lanes = ctl_q.lanes;
    assign shift_req_byte  = ctl_q.data;
    assign active          = (ctl_q.state != ST_IDLE);
    assign busy            = (ctl_q.state == ST_SH_REQ)  || (ctl_q.state == ST_SH_WAIT) ||
                             (ctl_q.state == ST_MEM_REQ) || (ctl_q.state == ST_MEM_WAIT);

endmodule

// File: rtl/flash_dma_engine.sv
module flash_dma_engine
    import flash_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter int MAX_RD = 2080,
    parameter int MAX_WR = 520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [7:0]        mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    output logic              shift_req_valid,
    input  logic              shift_req_ready,
    output logic              shift_req_tx,
    output logic [1:0]        shift_req_lanes,
    output logic [7:0]        shift_req_byte,
    input  logic              shift_done_valid,
    input  logic [7:0]        shift_done_byte,
    output logic              dma_busy,
    output logic              dma_irq
);

    logic              start;
    dma_dir_e          start_dir;
    logic [ADDR_W-1:0] base_addr;
    logic [LEN_W-1:0]  byte_len;
    logic [1:0]        lane_code;
    logic              run_active;
    logic              run_done;

    flash_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .run_active (run_active),
        .run_done   (run_done),
        .start      (start),
        .start_dir  (start_dir),
        .base_addr  (base_addr),
        .byte_len   (byte_len),
        .lane_code  (lane_code),
        .irq        (dma_irq)
    );

    flash_dma_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_RD(MAX_RD), .MAX_WR(MAX_WR)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (start),
        .start_dir        (start_dir),
        .base_addr        (base_addr),
        .byte_len         (byte_len),
        .lane_code        (lane_code),
        .mem_req_valid    (mem_req_valid),
        .mem_req_ready    (mem_req_ready),
        .mem_req_write    (mem_req_write),
        .mem_req_addr     (mem_req_addr),
        .mem_req_wdata    (mem_req_wdata),
        .mem_rsp_valid    (mem_rsp_valid),
        .mem_rsp_data     (mem_rsp_data),
        .shift_req_valid  (shift_req_valid),
        .shift_req_ready  (shift_req_ready),
        .shift_req_tx     (shift_req_tx),
        .shift_req_lanes  (shift_req_lanes),
        .shift_req_byte   (shift_req_byte),
        .shift_done_valid (shift_done_valid),
        .shift_done_byte  (shift_done_byte),
        .busy             (dma_busy),
        .active           (run_active),
        .run_done         (run_done)
    );

endmodule

// File: rtl/flash_dma_checker.sv
module flash_dma_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [7:0]        mem_req_wdata,
    input logic              shift_req_valid,
    input logic              shift_req_ready,
    input logic              shift_req_tx,
    input logic [1:0]        shift_req_lanes,
    input logic [7:0]        shift_req_byte,
    input logic              dma_busy,
    input logic              dma_irq
);

    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (!dma_busy) begin
            seen_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            seen_q <= 1'b1;
            last_q <= mem_req_addr;
        end
    end

    // R1: nothing is requested outside a run
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_busy |-> (!mem_req_valid && !shift_req_valid));

    // R2 / R3: consecutive memory requests step the address by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && seen_q && dma_busy) |-> (mem_req_addr == last_q + 1'b1));

    // R7: the interrupt never rises while, or right after, busy is high
    a_r7_busy_before_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_irq) |-> (!dma_busy && !$past(dma_busy)));

    // R11: a stalled memory request holds still
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_write)));

    // R11: a stalled shift request holds still
    a_r11_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_req_valid && !shift_req_ready) |=>
        (shift_req_valid && $stable(shift_req_tx) && $stable(shift_req_lanes) && $stable(shift_req_byte)));

endmodule

bind flash_dma_engine flash_dma_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_write   (mem_req_write),
    .mem_req_addr    (mem_req_addr),
    .mem_req_wdata   (mem_req_wdata),
    .shift_req_valid (shift_req_valid),
    .shift_req_ready (shift_req_ready),
    .shift_req_tx    (shift_req_tx),
    .shift_req_lanes (shift_req_lanes),
    .shift_req_byte  (shift_req_byte),
    .dma_busy        (dma_busy),
    .dma_irq         (dma_irq)
);

// File: tb/tb_flash_dma_engine.sv
`timescale 1ns/1ps
module tb_flash_dma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [7:0]  mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        shift_req_valid, shift_req_tx;
    logic        shift_req_ready = 1'b0;
    logic [1:0]  shift_req_lanes;
    logic [7:0]  shift_req_byte;
    logic        shift_done_valid = 1'b0;
    logic [7:0]  shift_done_byte = '0;
    logic        dma_busy, dma_irq;

    always #2.5 clk = ~clk;

    flash_dma_engine dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .shift_req_valid(shift_req_valid), .shift_req_ready(shift_req_ready), .shift_req_tx(shift_req_tx),
        .shift_req_lanes(shift_req_lanes), .shift_req_byte(shift_req_byte),
        .shift_done_valid(shift_done_valid), .shift_done_byte(shift_done_byte),
        .dma_busy(dma_busy), .dma_irq(dma_irq)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [39:0] exp_mem_q[$];
    logic [7:0]  exp_tx_q[$];
    logic [1:0]  exp_lanes = '0;
    logic        exp_tx = 1'b0;
    int n_memwr = 0, n_memrd = 0, n_tx = 0, n_rx = 0;
    int rx_k = 0;
    int sh_wait = 0, rsp_wait = 0;
    logic sh_is_tx = 1'b0;
    logic [7:0] rsp_hold = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic irq_prev = 1'b0, busy_prev = 1'b0;

    function automatic logic [7:0] pat(int k);
        return 8'(k * 7 + 90);
    endfunction

    function automatic logic [7:0] hsh(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor and bus models, all at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

            shift_done_valid = 1'b0;
            if (sh_wait > 0) begin
                sh_wait--;
                if (sh_wait == 0) begin
                    shift_done_valid = 1'b1;
                    shift_done_byte  = sh_is_tx ? 8'h00 : pat(rx_k);
                    if (!sh_is_tx) rx_k++;
                end
            end
            shift_req_ready = lfsr[0] | lfsr[5];
            if (shift_req_valid && shift_req_ready) begin
                check(shift_req_lanes == exp_lanes, "R2/R3", "shift lanes", 64'(shift_req_lanes), 64'(exp_lanes));
                check(shift_req_tx == exp_tx, "R2/R3", "shift direction", 64'(shift_req_tx), 64'(exp_tx));
                if (shift_req_tx) begin
                    n_tx++;
                    if (exp_tx_q.size() == 0)
                        check(1'b0, "R3", "unexpected shift send", 64'(shift_req_byte), 64'hFFFF);
                    else begin
                        logic [7:0] e;
                        e = exp_tx_q.pop_front();
                        check(shift_req_byte == e, "R3", "shift send byte", 64'(shift_req_byte), 64'(e));
                    end
                end else n_rx++;
                sh_is_tx = shift_req_tx;
                sh_wait  = 1 + int'(lfsr[2:1]);
            end

            mem_rsp_valid = 1'b0;
            if (rsp_wait > 0) begin
                rsp_wait--;
                if (rsp_wait == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rsp_hold;
                end
            end
            mem_req_ready = lfsr[1] | lfsr[7];
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    n_memwr++;
                    if (exp_mem_q.size() == 0)
                        check(1'b0, "R2", "unexpected memory write", {mem_req_addr, mem_req_wdata}, 64'hFFFF);
                    else begin
                        logic [39:0] e;
                        e = exp_mem_q.pop_front();
                        check({mem_req_addr, mem_req_wdata} == e, "R2", "memory write addr/data",
                              {mem_req_addr, mem_req_wdata}, 64'(e));
                    end
                end else begin
                    n_memrd++;
                    rsp_hold = hsh(mem_req_addr);
                    rsp_wait = 1 + int'(lfsr[4:3]);
                end
            end

            if (dma_irq && !irq_prev)
                check(!dma_busy && !busy_prev, "R7", "busy low before irq", {busy_prev, dma_busy}, 0);
            irq_prev  = dma_irq;
            busy_prev = dma_busy;
        end
    end

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_pending(string req);
        logic [31:0] v;
        bit got = 1'b0;
        for (int i = 0; i < 40000 && !got; i++) begin
            @(negedge clk);
            reg_read(8'h20, v);
            got = v[0];
        end
        check(got, req, "pending flag after run", 64'(got), 1);
    endtask

    task automatic clear_counts();
        n_memwr = 0; n_memrd = 0; n_tx = 0; n_rx = 0; rx_k = 0;
    endtask

    task automatic run_read(logic [31:0] base, logic [1:0] lanes, int cnt, int exp_n, string req);
        clear_counts();
        exp_lanes = lanes; exp_tx = 1'b0;
        for (int k = 0; k < exp_n; k++) exp_mem_q.push_back({base + 32'(k), pat(k)});
        reg_write(8'h1C, base);
        reg_write(8'h24, {2'b00, lanes, 28'(cnt)});
        reg_write(8'h18, 32'd0);
        check(dma_busy == 1'b1, "R7", "busy after read trigger", 64'(dma_busy), 1);
        wait_pending(req);
        check(n_memwr == exp_n, req, "memory writes in read run", 64'(n_memwr), 64'(exp_n));
        check(n_rx == exp_n && n_tx == 0 && n_memrd == 0, req, "shift receives in read run", 64'(n_rx), 64'(exp_n));
        check(exp_mem_q.size() == 0, req, "read run queue drained", 64'(exp_mem_q.size()), 0);
    endtask

    task automatic run_write(logic [31:0] base, logic [1:0] lanes, int cnt, int exp_n, bit poke, string req);
        clear_counts();
        exp_lanes = lanes; exp_tx = 1'b1;
        for (int k = 0; k < exp_n; k++) exp_tx_q.push_back(hsh(base + 32'(k)));
        reg_write(8'h1C, base);
        reg_write(8'h24, {2'b00, lanes, 28'(cnt)});
        reg_write(8'h18, 32'd1);
        check(dma_busy == 1'b1, "R7", "busy after write trigger", 64'(dma_busy), 1);
        if (poke) begin
            // R6: second trigger mid-run with a new length must not matter
            repeat (10) @(negedge clk);
            reg_write(8'h24, 32'd3);
            reg_write(8'h18, 32'd0);
        end
        wait_pending(req);
        check(n_tx == exp_n, req, "shift sends in write run", 64'(n_tx), 64'(exp_n));
        check(n_memrd == exp_n, req, "memory reads in write run", 64'(n_memrd), 64'(exp_n));
        check(n_memwr == 0 && n_rx == 0, "R6", "no flash-to-memory traffic in write run", 64'(n_memwr), 0);
        check(exp_tx_q.size() == 0, req, "write run queue drained", 64'(exp_tx_q.size()), 0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(dma_busy == 0 && dma_irq == 0, "R1", "busy/irq after reset", {dma_busy, dma_irq}, 0);
        check(mem_req_valid == 0 && shift_req_valid == 0, "R1", "no requests after reset",
              {mem_req_valid, shift_req_valid}, 0);
        reg_read(8'h00, v); check(v == 0, "R1", "config reset", v, 0);
        reg_read(8'h1C, v); check(v == 0, "R1", "address reset", v, 0);
        reg_read(8'h20, v); check(v == 0, "R1", "status reset", v, 0);
        reg_read(8'h24, v); check(v == 0, "R1", "length reset", v, 0);

        // R10: readback
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, v); check(v == 32'h0010_0000, "R10", "config readback", v, 32'h0010_0000);
        reg_write(8'h1C, 32'hDEAD_BEEF);
        reg_read(8'h1C, v); check(v == 32'hDEAD_BEEF, "R10", "address readback", v, 32'hDEAD_BEEF);
        reg_write(8'h24, 32'hFFFF_FFFF);
        reg_read(8'h24, v); check(v == 32'h3000_0FFF, "R10", "length readback", v, 32'h3000_0FFF);
        reg_read(8'h18, v); check(v == 0, "R10", "trigger reads zero", v, 0);
        reg_read(8'h30, v); check(v == 0, "R10", "unmapped offset reads zero", v, 0);

        // R2: flash-to-memory, quad lanes, irq enabled
        run_read(32'h1000_0F00, 2'd2, 37, 37, "R2");
        check(dma_irq == 1'b1, "R9", "irq with enable and pending", 64'(dma_irq), 1);

        // R8: W1C
        reg_write(8'h20, 32'h0);
        reg_read(8'h20, v); check(v[0] == 1'b1, "R8", "write 0 keeps pending", 64'(v[0]), 1);
        reg_write(8'h20, 32'h1);
        reg_read(8'h20, v); check(v[0] == 1'b0, "R8", "write 1 clears pending", 64'(v[0]), 0);
        check(dma_irq == 1'b0, "R9", "irq low after clear", 64'(dma_irq), 0);

        // R3 + R6: memory-to-flash with address wrap and a mid-run trigger
        run_write(32'hFFFF_FFF0, 2'd1, 45, 45, 1'b1, "R3");
        reg_write(8'h20, 32'h1);

        // R5 + R9: zero length with the interrupt disabled
        reg_write(8'h00, 32'h0);
        clear_counts();
        reg_write(8'h24, 32'h0);
        reg_write(8'h18, 32'd1);
        check(dma_busy == 1'b0, "R5", "busy stays low for zero length", 64'(dma_busy), 0);
        @(negedge clk);
        reg_read(8'h20, v); check(v[0] == 1'b1, "R5", "zero length sets pending", 64'(v[0]), 1);
        check(n_memwr + n_memrd + n_tx + n_rx == 0, "R5", "zero length issues no requests",
              64'(n_memwr + n_memrd + n_tx + n_rx), 0);
        check(dma_irq == 1'b0, "R9", "irq masked when disabled", 64'(dma_irq), 0);
        reg_write(8'h00, 32'h0010_0000);
        check(dma_irq == 1'b1, "R9", "irq appears on enable", 64'(dma_irq), 1);
        reg_write(8'h20, 32'h1);

        // R4: clamping in both directions
        run_read(32'h0000_2000, 2'd0, 2100, 2080, "R4");
        reg_write(8'h20, 32'h1);
        run_write(32'h0000_8000, 2'd2, 600, 520, 1'b0, "R4");
        reg_write(8'h20, 32'h1);
        // R2 again with single lane and an exact-limit count
        run_read(32'h4000_0000, 2'd0, 2080, 2080, "R2");
        reg_write(8'h20, 32'h1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule